// File: doc/BRIEF.md
# Cell Bleed Balancing Controller

This controller decides, once per voltage poll of a three-cell series stack, whether any cells must be bled down to restore balance. Every cell has a sticky flag. The flag is set when that cell's overvoltage comparison reports a hit at any point during the poll. At the poll-end strobe the flags are read and then cleared. If one or more cells are flagged, but not every cell, the controller asks the charge path to pause and turns on a bleed output for each flagged cell.

Each bleed output then stays on until its own cell reports that it has fallen to the target level. The outputs therefore drop out one at a time. The charge pause is released in the same cycle that the last bleed turns off. When the stack enters its low-current sleep state, the controller cancels any balancing in progress and discards pending flags. It accepts no new work until sleep ends.

The three bleed pins differ in polarity. Cells 1 and 2, at bit indices 0 and 1, drive an external low-side switch and so are active low. Cell 3, at bit index 2, drives a high-side switch and so is active high. An asynchronous active-low reset is released to the logic through a two-stage synchronizer.

Top module: `cbl_balance_ctrl`

## Requirements
- R1: After reset the bleed pins read 3'b011 (no cell bleeding) and `charge_hold` is 0.
- R2: A cell's flag is set by a high `cell_ov` bit in any cycle of a poll and holds until the poll ends. Hits on different cells in different cycles of one poll combine.
- R3: A poll that ends with no flag set and no `cell_ov` bit high starts no balancing. Pins and `charge_hold` stay idle.
- R4: A poll that ends with all three cells flagged starts no balancing. The flags are cleared all the same, so a following empty poll also starts nothing.
- R5: A poll that ends with one or two cells flagged (counting `cell_ov` in the strobe cycle) raises `charge_hold` in the next cycle. In that same cycle it turns on exactly the bleeds of the flagged cells.
- R6: While balancing, a high `cell_at_level` bit turns off that cell's bleed in the next cycle. The other bleeds are not affected. A level indication for a cell that is not bleeding has no effect.
- R7: `charge_hold` is high exactly while at least one bleed is on. It falls in the same cycle that the last bleed turns off.
- R8: While balancing, `cell_ov` and `poll_end` are ignored. No bleed is added, and hits seen during balancing do not carry into the next poll.
- R9: A high `sleep_mode` turns off every bleed and `charge_hold` in the next cycle, and clears all flags. While it stays high, `cell_ov` and `poll_end` have no effect.
- R10: Pin polarity: `bleed_pin[0]` (cell 1) and `bleed_pin[1]` (cell 2) are 0 when bleeding. `bleed_pin[2]` (cell 3) is 1 when bleeding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cell_ov | input | 3 | Per-cell overvoltage hit from the current poll |
| poll_end | input | 1 | One-cycle strobe marking the end of a poll |
| cell_at_level | input | 3 | Per-cell indication that the cell has fallen to the bleed target |
| sleep_mode | input | 1 | Stack is in low-current sleep; balancing is locked out |
| bleed_pin | output | 3 | Bleed drives; bits 0 and 1 are active low, bit 2 is active high |
| charge_hold | output | 1 | Request to pause charging while balancing |

## Verification
The poll decision is exercised with four kinds of poll. An empty poll separates "nothing flagged" from a stale flag. A poll with hits on two cells spread over different cycles shows that the flags accumulate rather than capture a single cycle. A poll with all three cells flagged confirms the skip rule and that the flags are still cleared. A poll with only cell 3 flagged exposes the polarity of the high-side pin on its own.

The release order is driven one cell at a time, with level indications also sent to idle cells. This separates independent release from release of all bleeds together. Long runs with random hits, strobes, level indications and sleep pulses then compare every cycle against a behavioural model. These runs catch interactions between sleep and in-flight balancing.

// File: rtl/cbl_pkg.sv
package cbl_pkg;
  typedef enum logic {
    ST_GATHER = 1'b0,
    ST_BLEED  = 1'b1
  } cbl_state_e;
endpackage

// File: rtl/cbl_reset_sync.sv
module cbl_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cbl_latch_bank.sv
module cbl_latch_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take_new,
  input  logic         drop_all,
  input  logic [N-1:0] hit,
  output logic [N-1:0] flag_q
);
  for (genvar i = 0; i < N; i++) begin : g_cell
    logic flag_d;
    logic flag_en;

    always_comb begin
      flag_en = drop_all | (take_new & hit[i]);
      flag_d  = drop_all ? 1'b0 : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q[i] <= 1'b0;
      else if (flag_en) flag_q[i] <= flag_d;
    end
  end
endmodule

// File: rtl/cbl_bleed_fsm.sv
module cbl_bleed_fsm
  import cbl_pkg::*;
#(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         poll_end,
  input  logic         sleep_mode,
  input  logic [N-1:0] snapshot,
  input  logic [N-1:0] at_level,
  output logic [N-1:0] bleed_q,
  output logic         balancing,
  output logic         take_new,
  output logic         drop_all
);
  cbl_state_e   st_q, st_d;
  logic [N-1:0] bleed_d;
  logic [N-1:0] remain;
  logic         qualify;
  logic         st_en;
  logic         bleed_en;

  always_comb begin
    remain  = bleed_q & ~at_level;
    qualify = (|snapshot) && !(&snapshot);
    st_d    = st_q;
    bleed_d = bleed_q;
    if (sleep_mode) begin
      st_d    = ST_GATHER;
      bleed_d = '0;
    end else if (st_q == ST_BLEED) begin
      bleed_d = remain;
      if (remain == '0) st_d = ST_GATHER;
    end else if (poll_end && qualify) begin
      st_d    = ST_BLEED;
      bleed_d = snapshot;
    end
  end

  assign st_en    = (st_d != st_q);
  assign bleed_en = (bleed_d != bleed_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= ST_GATHER;
    else if (st_en) st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        bleed_q <= '0;
    else if (bleed_en) bleed_q <= bleed_d;
  end

  assign balancing = (st_q == ST_BLEED);
  assign take_new  = (st_q == ST_GATHER) && !sleep_mode && !poll_end;
  assign drop_all  = sleep_mode || ((st_q == ST_GATHER) && poll_end);
endmodule

// File: rtl/cbl_pin_drive.sv
module cbl_pin_drive #(
  parameter int         N        = 3,
  parameter logic [N-1:0] ACT_HIGH = 3'b100
) (
  input  logic [N-1:0] bleed,
  output logic [N-1:0] pin
);
  for (genvar i = 0; i < N; i++) begin : g_pol
    if (ACT_HIGH[i]) begin : g_high
      assign pin[i] = bleed[i];
    end else begin : g_low
      assign pin[i] = ~bleed[i];
    end
  end
endmodule

// File: rtl/cbl_balance_ctrl.sv
module cbl_balance_ctrl #(
  parameter int           N        = 3,
  parameter logic [N-1:0] ACT_HIGH = 3'b100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cell_ov,
  input  logic         poll_end,
  input  logic [N-1:0] cell_at_level,
  input  logic         sleep_mode,
  output logic [N-1:0] bleed_pin,
  output logic         charge_hold
);
  logic         rst_core_n;
  logic [N-1:0] flag_q;
  logic [N-1:0] snapshot;
  logic [N-1:0] bleed_q;
  logic         take_new;
  logic         drop_all;
  logic         balancing;

  cbl_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  cbl_latch_bank #(.N(N)) u_flags (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .take_new (take_new),
    .drop_all (drop_all),
    .hit      (cell_ov),
    .flag_q   (flag_q)
  );

  assign snapshot = flag_q | cell_ov;

  cbl_bleed_fsm #(.N(N)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .poll_end   (poll_end),
    .sleep_mode (sleep_mode),
    .snapshot   (snapshot),
    .at_level   (cell_at_level),
    .bleed_q    (bleed_q),
    .balancing  (balancing),
    .take_new   (take_new),
    .drop_all   (drop_all)
  );

  cbl_pin_drive #(.N(N), .ACT_HIGH(ACT_HIGH)) u_pins (
    .bleed (bleed_q),
    .pin   (bleed_pin)
  );

  assign charge_hold = balancing;
endmodule

// File: rtl/cbl_balance_chk.sv
module cbl_balance_chk #(
  parameter int           N        = 3,
  parameter logic [N-1:0] ACT_HIGH = 3'b100
) (
  input logic         clk,
  input logic         rst_n,
  input logic         poll_end,
  input logic         sleep_mode,
  input logic [N-1:0] cell_at_level,
  input logic [N-1:0] bleed_pin,
  input logic         charge_hold
);
  logic [N-1:0] act;
  assign act = ~(bleed_pin ^ ACT_HIGH);

  AST_HOLD_TRACKS_BLEED: assert property (@(posedge clk) disable iff (!rst_n)
    charge_hold == (act != '0)); // R7

  AST_NEVER_ALL_BLEED: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(act) != N); // R4

  AST_SLEEP_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_mode |=> (!charge_hold && act == '0)); // R9

  AST_NO_BLEED_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    charge_hold |=> ((act & ~$past(act)) == '0)); // R8

  AST_LEVEL_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    charge_hold |=> ((act & $past(cell_at_level)) == '0)); // R6

  AST_START_ONLY_AT_POLL_END: assert property (@(posedge clk) disable iff (!rst_n)
    (!charge_hold && !poll_end) |=> !charge_hold); // R5
endmodule

bind cbl_balance_ctrl cbl_balance_chk #(.N(N), .ACT_HIGH(ACT_HIGH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .poll_end      (poll_end),
  .sleep_mode    (sleep_mode),
  .cell_at_level (cell_at_level),
  .bleed_pin     (bleed_pin),
  .charge_hold   (charge_hold)
);

// File: tb/tb_cbl_balance_ctrl.sv
`timescale 1ns/1ps
module tb_cbl_balance_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] cell_ov;
  logic       poll_end;
  logic [2:0] cell_at_level;
  logic       sleep_mode;
  logic [2:0] bleed_pin;
  logic       charge_hold;

  integer n_tests = 0;
  integer n_fail  = 0;

  // behavioural reference
  logic [2:0] m_flag;
  logic [2:0] m_bleed;
  logic       m_busy;

  always #4 clk = ~clk;

  cbl_balance_ctrl dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .cell_ov       (cell_ov),
    .poll_end      (poll_end),
    .cell_at_level (cell_at_level),
    .sleep_mode    (sleep_mode),
    .bleed_pin     (bleed_pin),
    .charge_hold   (charge_hold)
  );

  always @(posedge clk) begin
    logic [2:0] ev;
    if (!rst_n) begin
      m_flag = 3'b000; m_bleed = 3'b000; m_busy = 1'b0;
    end else if (sleep_mode) begin
      m_flag = 3'b000; m_bleed = 3'b000; m_busy = 1'b0;
    end else if (m_busy) begin
      m_bleed = m_bleed & ~cell_at_level;
      if (m_bleed == 3'b000) m_busy = 1'b0;
    end else begin
      ev = m_flag | cell_ov;
      if (poll_end) begin
        m_flag = 3'b000;
        if (ev != 3'b000 && ev != 3'b111) begin
          m_bleed = ev; m_busy = 1'b1;
        end
      end else begin
        m_flag = ev;
      end
    end
  end

  function automatic logic [2:0] pins_for(input logic [2:0] b);
    // cells 1,2 active low; cell 3 active high (R10)
    return {b[2], ~b[1], ~b[0]};
  endfunction

  task automatic check(input string req, input logic [2:0] exp_pin, input logic exp_hold);
    n_tests = n_tests + 1;
    if (bleed_pin !== exp_pin || charge_hold !== exp_hold) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: pins=%b hold=%b expected pins=%b hold=%b",
               req, bleed_pin, charge_hold, exp_pin, exp_hold);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    if (rst_n) check("MODEL R2/R5/R6", pins_for(m_bleed), m_busy);
  endtask

  task automatic idle_inputs();
    cell_ov = 3'b000; poll_end = 1'b0; cell_at_level = 3'b000; sleep_mode = 1'b0;
  endtask

  initial begin
    #1_500_000;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    idle_inputs();
    repeat (3) @(negedge clk);
    check("R1 reset", 3'b011, 1'b0);
    rst_n = 1'b1;
    repeat (4) tick();
    check("R1 after release", 3'b011, 1'b0);

    // R2/R5/R10: hits on cells 1 and 2 in separate cycles
    cell_ov = 3'b001; tick();
    cell_ov = 3'b000; tick();
    cell_ov = 3'b010; tick();
    cell_ov = 3'b000; tick();
    check("R2 no action before poll end", 3'b011, 1'b0);
    poll_end = 1'b1; tick(); poll_end = 1'b0;
    check("R5 bleed cells 1,2", 3'b000, 1'b1);

    // R6: level on idle cell 3 no effect; R8: ov and poll_end ignored
    cell_at_level = 3'b100; cell_ov = 3'b111; poll_end = 1'b1; tick();
    cell_at_level = 3'b000; cell_ov = 3'b000; poll_end = 1'b0;
    check("R6 idle-cell level ignored", 3'b000, 1'b1);
    check("R8 no bleed added", 3'b000, 1'b1);
    cell_at_level = 3'b001; tick(); cell_at_level = 3'b000;
    check("R6 cell 1 released alone", 3'b001, 1'b1);
    tick();
    check("R7 hold kept while one bleeds", 3'b001, 1'b1);
    cell_at_level = 3'b010; tick(); cell_at_level = 3'b000;
    check("R7 hold drops with last bleed", 3'b011, 1'b0);

    // R8/R3: hits seen while balancing did not persist
    poll_end = 1'b1; tick(); poll_end = 1'b0;
    check("R8 empty poll after balancing", 3'b011, 1'b0);
    poll_end = 1'b1; tick(); poll_end = 1'b0;
    check("R3 empty poll", 3'b011, 1'b0);

    // R4: all three flagged
    cell_ov = 3'b011; tick();
    cell_ov = 3'b100; poll_end = 1'b1; tick();
    cell_ov = 3'b000; poll_end = 1'b0;
    check("R4 all flagged skips", 3'b011, 1'b0);
    poll_end = 1'b1; tick(); poll_end = 1'b0;
    check("R4 flags cleared", 3'b011, 1'b0);

    // R10: only cell 3, active high pin
    cell_ov = 3'b100; poll_end = 1'b1; tick();
    cell_ov = 3'b000; poll_end = 1'b0;
    check("R10 cell 3 active high", 3'b111, 1'b1);

    // R9: sleep cancels balancing, inputs ignored while asleep
    sleep_mode = 1'b1; tick();
    check("R9 sleep cancels", 3'b011, 1'b0);
    cell_ov = 3'b001; tick();
    poll_end = 1'b1; cell_ov = 3'b010; tick();
    poll_end = 1'b0; cell_ov = 3'b000;
    check("R9 poll ignored asleep", 3'b011, 1'b0);
    sleep_mode = 1'b0; poll_end = 1'b1; tick(); poll_end = 1'b0;
    check("R9 nothing retained from sleep", 3'b011, 1'b0);

    // R9: sleep clears a pending flag
    cell_ov = 3'b001; tick(); cell_ov = 3'b000;
    sleep_mode = 1'b1; tick(); sleep_mode = 1'b0;
    poll_end = 1'b1; tick(); poll_end = 1'b0;
    check("R9 pending flag dropped", 3'b011, 1'b0);

    // random phase, compared against the model every cycle
    void'($urandom(32'd7));
    for (int k = 0; k < 6000; k++) begin
      cell_ov       = {($urandom % 6 == 0), ($urandom % 6 == 0), ($urandom % 6 == 0)};
      poll_end      = ($urandom % 8 == 0);
      cell_at_level = {($urandom % 4 == 0), ($urandom % 4 == 0), ($urandom % 4 == 0)};
      sleep_mode    = ($urandom % 40 == 0);
      tick();
    end
    idle_inputs();
    tick();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule